// File: doc/BRIEF.md
# Multi-Mode Word Register and Counter

This block holds one 12-bit word and changes it once per step. A 3-bit operation code picks what happens on each step. The word can stay as it is, take the parallel input, or rotate one place in either direction. It can also count up or down by one or by two, wrapping modulo 4096. A synchronous, active-high clear forces the word to zero on a step, whatever the operation code says.

The block runs on a fast system clock. The step comes from a slower line, `step_in`, which the block samples on every system clock edge. A step happens on the system clock edge where `step_in` is first seen high after being low. The parameter `SAMPLED_STEP` can be set to 0. The block then steps on every system clock edge and ignores `step_in`. The operation code only selects the next operation. Changing it never alters the stored word.

Top module: `opsel_register`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `dout` is 0x000.
- R2: A step with `clr` = 1 makes `dout` 0x000, for all eight values of `func`.
- R3: A step with `func` = 3'b000 leaves `dout` unchanged.
- R4: A step with `func` = 3'b001 copies `din` into `dout`.
- R5: A step with `func` = 3'b010 rotates `dout` one place left. Bit 11 moves to bit 0.
- R6: A step with `func` = 3'b011 rotates `dout` one place right. Bit 0 moves to bit 11.
- R7: A step with `func` = 3'b100 adds 1 to `dout`, and 3'b101 adds 2, both modulo 4096. So 0xFFF+1 = 0x000 and 0xFFF+2 = 0x001.
- R8: A step with `func` = 3'b110 subtracts 1 from `dout`, and 3'b111 subtracts 2, both modulo 4096. So 0x000-1 = 0xFFF and 0x001-2 = 0xFFF.
- R9: With `SAMPLED_STEP` = 1, one operation happens on each low-to-high change of `step_in`. `dout` does not change while `step_in` stays high, stays low, or falls, whatever `func`, `din` and `clr` are doing.
- R10: Changing `func`, `din` or `clr` between steps does not alter `dout`. The next step starts from the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the word and the step detector |
| step_in | input | 1 | Sampled step line; a rising change triggers one operation |
| clr | input | 1 | Synchronous clear, active high, applied on a step |
| func | input | 3 | Operation code: 000 hold, 001 load, 010 rotate left, 011 rotate right, 100 +1, 101 +2, 110 -1, 111 -2 |
| din | input | 12 | Parallel data loaded by code 001 |
| dout | output | 12 | Stored word |

## Verification
The edge of `step_in` is detected in the same system clock edge that first samples it high. The word register loads in that same edge, so each result is due exactly one system clock edge after `step_in` goes high. The bench drives inputs on falling edges. It raises `step_in` together with `func`, `clr` and `din`, and compares `dout` at the next falling edge. It then changes `func` and `din` while `step_in` is still high and checks that `dout` has not moved one cycle later. It lowers `step_in` and checks once more a cycle after that. This covers R9 and R10 on every step.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

    // Operation codes; the encoding is the external contract of func
    typedef enum logic [2:0] {
        OP_HOLD = 3'b000,
        OP_LOAD = 3'b001,
        OP_ROTL = 3'b010,
        OP_ROTR = 3'b011,
        OP_INC1 = 3'b100,
        OP_INC2 = 3'b101,
        OP_DEC1 = 3'b110,
        OP_DEC2 = 3'b111
    } opsel_e;

    localparam int unsigned OPSEL_BITS = 3;

endpackage

// File: rtl/opsel_edge.sv
module opsel_edge #(
    parameter bit SAMPLED_STEP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic fire
);

    generate
        if (SAMPLED_STEP) begin : g_sampled
            typedef struct packed {
                logic prev;
            } edge_state_t;

            edge_state_t st_d, st_q;

            always_comb begin
                st_d      = st_q;
                st_d.prev = line_in;
                fire      = line_in & ~st_q.prev;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            // R9: a detected edge can never repeat on the following cycle
            a_r9_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
                fire |=> !fire);
        end else begin : g_free_run
            logic unused_pins;
            assign unused_pins = line_in & rst_n;
            assign fire        = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/opsel_next.sv
module opsel_next
    import opsel_pkg::*;
#(
    parameter int unsigned WIDTH = 12
) (
    input  logic [WIDTH-1:0]      cur,
    input  logic [WIDTH-1:0]      din,
    input  logic [OPSEL_BITS-1:0] func,
    input  logic                  clr,
    output logic [WIDTH-1:0]      nxt
);

    localparam logic [WIDTH-1:0] STEP_ONE = WIDTH'(1);
    localparam logic [WIDTH-1:0] STEP_TWO = WIDTH'(2);

    opsel_e op;

    always_comb begin
        op = opsel_e'(func);
        if (clr) begin
            nxt = '0;
        end else begin
            unique case (op)
                OP_HOLD: nxt = cur;
                OP_LOAD: nxt = din;
                OP_ROTL: nxt = {cur[WIDTH-2:0], cur[WIDTH-1]};
                OP_ROTR: nxt = {cur[0], cur[WIDTH-1:1]};
                OP_INC1: nxt = cur + STEP_ONE;
                OP_INC2: nxt = cur + STEP_TWO;
                OP_DEC1: nxt = cur - STEP_ONE;
                OP_DEC2: nxt = cur - STEP_TWO;
                default: nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/opsel_register.sv
module opsel_register
    import opsel_pkg::*;
#(
    parameter int unsigned WIDTH        = 12,
    parameter bit          SAMPLED_STEP = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_in,
    input  logic                  clr,
    input  logic [OPSEL_BITS-1:0] func,
    input  logic [WIDTH-1:0]      din,
    output logic [WIDTH-1:0]      dout
);

    localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);
    localparam logic [WIDTH-1:0] TWO_W = WIDTH'(2);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } word_state_t;

    word_state_t st_d, st_q;
    logic             fire;
    logic [WIDTH-1:0] nxt;

    opsel_edge #(
        .SAMPLED_STEP(SAMPLED_STEP)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(step_in),
        .fire   (fire)
    );

    opsel_next #(
        .WIDTH(WIDTH)
    ) u_next (
        .cur (st_q.word),
        .din (din),
        .func(func),
        .clr (clr),
        .nxt (nxt)
    );

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.word = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.word;

    // R1: reset value
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (st_q.word == '0);
        end
    end

    // R2: clear wins over every code
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr) |=> (dout == '0));

    // R9, R10: no step, no change
    a_r9_no_step_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(dout));

    // R3: hold code
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr && func == OP_HOLD) |=> $stable(dout));

    // R4: load code
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr && func == OP_LOAD) |=> (dout == $past(din)));

    // R5: rotate left
    a_r5_rotl: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr && func == OP_ROTL) |=>
        (dout == {$past(dout[WIDTH-2:0]), $past(dout[WIDTH-1])}));

    // R6: rotate right
    a_r6_rotr: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr && func == OP_ROTR) |=>
        (dout == {$past(dout[0]), $past(dout[WIDTH-1:1])}));

    // R7: up by two, modulo
    a_r7_inc2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr && func == OP_INC2) |=> (dout - $past(dout) == TWO_W));

    // R8: down by one, modulo
    a_r8_dec1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr && func == OP_DEC1) |=> ($past(dout) - dout == ONE_W));

endmodule

// File: tb/sim_opsel_register.sv
`timescale 1ns/1ps
module sim_opsel_register;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_in = 1'b0;
    logic        clr = 1'b0;
    logic [2:0]  func = 3'b000;
    logic [11:0] din = 12'h000;
    logic [11:0] dout;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [11:0] model  = 12'h000;

    always #2.5 clk = ~clk;

    opsel_register u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_in(step_in),
        .clr    (clr),
        .func   (func),
        .din    (din),
        .dout   (dout)
    );

    function automatic logic [11:0] ref_next(logic [11:0] x, logic [2:0] f,
                                             logic c, logic [11:0] d);
        int v;
        v = int'(x);
        if (c) return 12'h000;
        case (f)
            3'd0: v = v;
            3'd1: v = int'(d);
            3'd2: v = ((v * 2) + (v / 2048)) % 4096;
            3'd3: v = (v / 2) + ((v % 2) * 2048);
            3'd4: v = (v + 1) % 4096;
            3'd5: v = (v + 2) % 4096;
            3'd6: v = (v + 4095) % 4096;
            default: v = (v + 4094) % 4096;
        endcase
        return v[11:0];
    endfunction

    task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dout=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One step followed by R9/R10 quiet cycles
    task automatic step(logic [2:0] f, logic c, logic [11:0] d, string req);
        @(negedge clk);
        func = f; clr = c; din = d; step_in = 1'b1;
        model = ref_next(model, f, c, d);
        @(negedge clk);
        chk(req, dout, model);
        func = 3'b101; din = ~d; clr = 1'b1;
        @(negedge clk);
        chk("R9 step held high", dout, model);
        step_in = 1'b0; func = 3'b001; clr = 1'b0;
        @(negedge clk);
        chk("R10 inputs changed with step low", dout, model);
    endtask

    function automatic string req_of(logic [2:0] f);
        case (f)
            3'd0: return "R3 hold";
            3'd1: return "R4 load";
            3'd2: return "R5 rotate left";
            3'd3: return "R6 rotate right";
            3'd4, 3'd5: return "R7 count up";
            default: return "R8 count down";
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: dout=%h expected run end", dout);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        chk("R1 in reset", dout, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", dout, 12'h000);

        // Sweep every code over 64 start values, corners first
        for (int f = 0; f < 8; f++) begin
            for (int i = 0; i < 64; i++) begin
                case (i)
                    0: v = 12'h000;
                    1: v = 12'h001;
                    2: v = 12'hFFE;
                    3: v = 12'hFFF;
                    4: v = 12'h800;
                    default: v = 12'((i * 331) ^ (i << 5) ^ 12'hA5A);
                endcase
                step(3'b001, 1'b0, v, "R4 load");
                step(3'(f), 1'b0, ~v, req_of(3'(f)));
            end
        end

        // R7 and R8 wrap corners named explicitly
        step(3'b001, 1'b0, 12'hFFF, "R4 load");
        step(3'b101, 1'b0, 12'h000, "R7 FFF+2");
        chk("R7 FFF+2 is 001", dout, 12'h001);
        step(3'b111, 1'b0, 12'h000, "R8 001-2");
        chk("R8 001-2 is FFF", dout, 12'hFFF);

        // R2: clear over each code from a nonzero word
        for (int f = 0; f < 8; f++) begin
            step(3'b001, 1'b0, 12'h9C3, "R4 load");
            step(3'(f), 1'b1, 12'h5A5, "R2 clear");
        end

        // Full cycles: up by one, down by two
        step(3'b001, 1'b0, 12'h000, "R4 load");
        for (int i = 0; i < 4096; i++) step(3'b100, 1'b0, 12'h000, "R7 full up cycle");
        chk("R7 back to start", dout, 12'h000);
        for (int i = 0; i < 2048; i++) step(3'b111, 1'b0, 12'h000, "R8 full down cycle");
        chk("R8 back to start", dout, 12'h000);

        // R10: code changes with no step; then 12 rotates return the word
        step(3'b001, 1'b0, 12'h321, "R4 load");
        for (int f = 0; f < 8; f++) begin
            @(negedge clk);
            func = 3'(f); din = 12'hEEE; clr = f[0];
            @(negedge clk);
            chk("R10 no step", dout, 12'h321);
        end
        for (int i = 0; i < 12; i++) step(3'b010, 1'b0, 12'h000, "R5 rotate left");
        chk("R5 twelve rotates", dout, 12'h321);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule